// File: doc/BRIEF.md
# Target-Request Handler for a Two-Wire Controller

This block sits on the controller side of an I3C-style two-wire bus. It watches the bus while it is idle. When a target pulls the data line low on its own, the block answers by driving the clock line at the slow open-drain rate. It shifts in the eight-bit header the target sends, then sorts the request into one of three kinds: an in-band interrupt from a target that holds an assigned dynamic address, a hot-join announcement, or an unrecognised header. The block drives the ninth clock itself and either acknowledges the request by holding the data line low or rejects it by leaving the line released.

A rejected request is closed with a STOP condition, and the bus is given one half clock period of free time. An accepted request produces a one-cycle status pulse, which either permits a read from the interrupting target or starts dynamic address assignment. After that pulse the block holds the clock low and hands the bus to the next engine, which frees it again with a release strobe. The clock divider is clamped so that each clock phase lasts at least 500 ns, whatever the configured value is.

Top module: `i3c_req_handler`

## Requirements
- R1: In the idle state `scl_o` is 1, `sda_oe` is 0 and `busy` is 0. The block leaves idle only when the synchronised `sda_i` reads 0 (two-stage synchroniser). It then raises `busy` and keeps `scl_o` high for one half period before the first falling edge.
- R2: The request phase runs nine clocks. Each low phase and each high phase lasts exactly HALF system cycles, where HALF is the larger of OD_HALF, ceil(500000 / CLK_PS) and 2. A clock period is therefore never shorter than 1 µs.
- R3: The header is sampled on each rising edge of `scl_o`, most significant bit first. Header bits 7..1 are the address and bit 0 is the direction bit, where 1 means read.
- R4: A header whose address field is 7'h02 is a hot-join, whatever its direction bit. With `hj_en`=1 it is acknowledged, and `daa_start` pulses for one cycle at the falling edge that ends the ninth clock.
- R5: A hot-join with `hj_en`=0 is rejected, and `hj_nack` pulses for one cycle at that same edge.
- R6: A header whose address equals a valid entry of `addr_tbl` (entry i is bits 7i+6..7i, valid when `addr_vld[i]`=1), with direction bit 1 and `ibi_en`=1, is acknowledged. `ibi_ack` then pulses for one cycle, and `ibi_addr` carries the address and changes only together with that pulse.
- R7: A header whose address matches a valid entry but whose direction bit is 0, or that arrives while `ibi_en`=0, is rejected and pulses `ibi_nack`.
- R8: A header that is neither 7'h02 nor a valid table address is rejected and pulses `unk_req`. Entries with `addr_vld` at 0 never match.
- R9: On an accepted request, `sda_oe` is 1 through both the low phase and the high phase of the ninth clock. On a rejected request it stays 0 there. `sda_oe` only rises while `scl_o` is low.
- R10: After a rejection, `sda_oe` goes to 1 for one low phase. `scl_o` then rises, `sda_oe` drops one half period later (the STOP), and the block returns to idle after one more half period.
- R11: After an acceptance, the block holds `scl_o` low with `sda_oe` at 0 and `busy` at 1 until `handoff_rel` is sampled high. It then releases `scl_o` and returns to idle one half period later.
- R12: During reset, `scl_o` is 1 and `sda_oe`, `busy` and all status pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_i | input | 1 | Data line as seen on the bus |
| addr_tbl | input | 7*NUM_TGT | Assigned dynamic addresses, one 7-bit entry per target |
| addr_vld | input | NUM_TGT | Valid flag per table entry |
| ibi_en | input | 1 | Permits acknowledgement of interrupts |
| hj_en | input | 1 | Permits acknowledgement of hot-joins |
| handoff_rel | input | 1 | Next engine frees the bus after an accepted request |
| scl_o | output | 1 | Clock line level driven by the controller |
| sda_oe | output | 1 | Pull data line low when 1 |
| busy | output | 1 | Request handling in progress |
| ibi_ack | output | 1 | Pulse: interrupt accepted, read permitted |
| ibi_addr | output | 7 | Address of the accepted interrupting target |
| daa_start | output | 1 | Pulse: hot-join accepted, start address assignment |
| hj_nack | output | 1 | Pulse: hot-join rejected |
| ibi_nack | output | 1 | Pulse: interrupt from a known target rejected |
| unk_req | output | 1 | Pulse: unrecognised header rejected |

## Verification
The bench aims at the header cases where sorting is easy to get wrong:
- A known address sent with the write direction. A design that ignored the direction bit would acknowledge it and raise `ibi_ack` where `ibi_nack` is due.
- An address that sits in a table entry marked invalid. A design that ignored the valid flags would accept this header as an interrupt, when it must be reported as unknown.
- The hot-join address sent with either direction bit, with the enable both on and off. A design that ignored the enable, or that demanded a particular direction bit, would pulse the wrong status output.

It also sets the divider below the legal minimum, so a design missing the clamp would show clock phases that are too short. Back-to-back requests expose an off-by-one in the STOP or bus-free timing, which would shift every later clock edge.

// File: rtl/i3c_req_pkg.sv
package i3c_req_pkg;

  // minimum duration of one open-drain clock phase, in picoseconds
  localparam int unsigned OD_MIN_PHASE_PS = 500000;
  localparam logic [6:0]  HOTJOIN_ADDR    = 7'h02;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_LO, S_HI, S_ACK_LO, S_ACK_HI,
    S_STP_LO, S_STP_HI, S_FREE, S_HOLD
  } req_st_t;

  typedef enum logic [1:0] {
    K_IBI = 2'd0,
    K_HJ  = 2'd1,
    K_UNK = 2'd2
  } req_kind_t;

  typedef struct packed {
    logic      ack;
    req_kind_t kind;
    logic [6:0] addr;
  } verdict_t;

endpackage

// File: rtl/i3c_req_sync.sv
module i3c_req_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i3c_req_match.sv
module i3c_req_match #(
  parameter int unsigned NUM_TGT = 4
) (
  input  logic [7*NUM_TGT-1:0] tbl,
  input  logic [NUM_TGT-1:0]   vld,
  input  logic [6:0]           addr,
  output logic                 hit
);
  logic [NUM_TGT-1:0] eq;

  generate
    for (genvar i = 0; i < NUM_TGT; i++) begin : g_ent
      assign eq[i] = vld[i] && (tbl[7*i +: 7] == addr);
    end
  endgenerate

  assign hit = |eq;
endmodule

// File: rtl/i3c_req_classify.sv
module i3c_req_classify
  import i3c_req_pkg::*;
(
  input  logic [7:0] hdr,
  input  logic       tbl_hit,
  input  logic       ibi_en,
  input  logic       hj_en,
  output verdict_t   vd
);
  always_comb begin
    vd.addr = hdr[7:1];
    if (hdr[7:1] == HOTJOIN_ADDR) begin
      vd.kind = K_HJ;
      vd.ack  = hj_en;
    end else if (tbl_hit) begin
      vd.kind = K_IBI;
      vd.ack  = hdr[0] && ibi_en;
    end else begin
      vd.kind = K_UNK;
      vd.ack  = 1'b0;
    end
  end
endmodule

// File: rtl/i3c_req_handler.sv
module i3c_req_handler
  import i3c_req_pkg::*;
#(
  parameter int unsigned NUM_TGT  = 4,
  parameter int unsigned OD_HALF  = 120,
  parameter int unsigned CLK_PS   = 5000,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sda_i,
  input  logic [7*NUM_TGT-1:0] addr_tbl,
  input  logic [NUM_TGT-1:0]   addr_vld,
  input  logic                 ibi_en,
  input  logic                 hj_en,
  input  logic                 handoff_rel,
  output logic                 scl_o,
  output logic                 sda_oe,
  output logic                 busy,
  output logic                 ibi_ack,
  output logic [6:0]           ibi_addr,
  output logic                 daa_start,
  output logic                 hj_nack,
  output logic                 ibi_nack,
  output logic                 unk_req
);
  localparam int unsigned MIN_HALF = (OD_MIN_PHASE_PS + CLK_PS - 1) / CLK_PS;
  localparam int unsigned HALF0    = (OD_HALF > MIN_HALF) ? OD_HALF : MIN_HALF;
  localparam int unsigned HALF     = (HALF0 < 2) ? 2 : HALF0;
  localparam int unsigned CW       = $clog2(HALF);
  localparam logic [CW-1:0] RELOAD = CW'(HALF - 1);

  req_st_t    st;
  logic [CW-1:0] cnt;
  logic [2:0] bitn;
  logic [7:0] shreg;
  verdict_t   verd, vd_now;
  logic       sda_s, hit;
  logic       tick;

  i3c_req_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d(sda_i), .q(sda_s)
  );

  i3c_req_match #(.NUM_TGT(NUM_TGT)) u_match (
    .tbl(addr_tbl), .vld(addr_vld), .addr(shreg[7:1]), .hit(hit)
  );

  i3c_req_classify u_cls (
    .hdr(shreg), .tbl_hit(hit), .ibi_en(ibi_en), .hj_en(hj_en), .vd(vd_now)
  );

  assign tick = (cnt == '0);
  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      shreg     <= '0;
      verd      <= '0;
      scl_o     <= 1'b1;
      sda_oe    <= 1'b0;
      ibi_ack   <= 1'b0;
      ibi_addr  <= '0;
      daa_start <= 1'b0;
      hj_nack   <= 1'b0;
      ibi_nack  <= 1'b0;
      unk_req   <= 1'b0;
    end else begin
      ibi_ack   <= 1'b0;
      daa_start <= 1'b0;
      hj_nack   <= 1'b0;
      ibi_nack  <= 1'b0;
      unk_req   <= 1'b0;
      if (!tick) cnt <= cnt - 1'b1;

      case (st)
        S_IDLE: begin
          if (!sda_s) begin
            st  <= S_START;
            cnt <= RELOAD;
          end
        end
        S_START: begin
          if (tick) begin
            scl_o <= 1'b0;
            bitn  <= '0;
            cnt   <= RELOAD;
            st    <= S_LO;
          end
        end
        S_LO: begin
          if (tick) begin
            scl_o <= 1'b1;
            shreg <= {shreg[6:0], sda_s};
            cnt   <= RELOAD;
            st    <= S_HI;
          end
        end
        S_HI: begin
          if (tick) begin
            scl_o <= 1'b0;
            cnt   <= RELOAD;
            if (bitn == 3'd7) begin
              verd   <= vd_now;
              sda_oe <= vd_now.ack;
              st     <= S_ACK_LO;
            end else begin
              bitn <= bitn + 1'b1;
              st   <= S_LO;
            end
          end
        end
        S_ACK_LO: begin
          if (tick) begin
            scl_o <= 1'b1;
            cnt   <= RELOAD;
            st    <= S_ACK_HI;
          end
        end
        S_ACK_HI: begin
          if (tick) begin
            scl_o <= 1'b0;
            cnt   <= RELOAD;
            if (verd.ack) begin
              sda_oe    <= 1'b0;
              st        <= S_HOLD;
              ibi_ack   <= (verd.kind == K_IBI);
              daa_start <= (verd.kind == K_HJ);
              if (verd.kind == K_IBI) ibi_addr <= verd.addr;
            end else begin
              sda_oe   <= 1'b1;
              st       <= S_STP_LO;
              hj_nack  <= (verd.kind == K_HJ);
              ibi_nack <= (verd.kind == K_IBI);
              unk_req  <= (verd.kind == K_UNK);
            end
          end
        end
        S_STP_LO: begin
          if (tick) begin
            scl_o <= 1'b1;
            cnt   <= RELOAD;
            st    <= S_STP_HI;
          end
        end
        S_STP_HI: begin
          if (tick) begin
            sda_oe <= 1'b0;
            cnt    <= RELOAD;
            st     <= S_FREE;
          end
        end
        S_FREE: begin
          if (tick) st <= S_IDLE;
        end
        S_HOLD: begin
          if (handoff_rel) begin
            scl_o <= 1'b1;
            cnt   <= RELOAD;
            st    <= S_FREE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i3c_req_chk.sv
module i3c_req_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_o,
  input logic       sda_oe,
  input logic       busy,
  input logic       ibi_ack,
  input logic [6:0] ibi_addr,
  input logic       daa_start,
  input logic       hj_nack,
  input logic       ibi_nack,
  input logic       unk_req
);
  // R12
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (scl_o && !sda_oe && !busy && !ibi_ack && !daa_start));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (scl_o && !sda_oe));

  // R1
  start_high_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> scl_o);

  // R2
  phase_min_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_o != $past(scl_o)) |=> $stable(scl_o));

  // R9
  sda_rise_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_o);

  // R8
  one_status_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ibi_ack, daa_start, hj_nack, ibi_nack, unk_req}));

  // R6
  addr_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ibi_addr) |-> ibi_ack);

  // R4
  pulse_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (ibi_ack || daa_start || hj_nack || ibi_nack || unk_req) |-> busy);
endmodule

bind i3c_req_handler i3c_req_chk u_req_chk (
  .clk(clk), .rst(rst), .scl_o(scl_o), .sda_oe(sda_oe), .busy(busy),
  .ibi_ack(ibi_ack), .ibi_addr(ibi_addr), .daa_start(daa_start),
  .hj_nack(hj_nack), .ibi_nack(ibi_nack), .unk_req(unk_req)
);

// File: tb/test_i3c_req_handler.sv
`timescale 1ns/1ps
module test_i3c_req_handler;
  localparam int NT = 4;
  localparam int HH = 100;   // 500 ns / 5 ns; OD_HALF=40 below must be clamped

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tgt_sda = 1'b1;
  logic handoff_rel = 1'b0;
  logic ibi_en = 1'b1, hj_en = 1'b1;
  logic [6:0] ta [NT];
  logic [NT-1:0] va;
  logic [7*NT-1:0] tbl_flat;
  logic sda_i, scl_o, sda_oe, busy, ibi_ack, daa_start, hj_nack, ibi_nack, unk_req;
  logic [6:0] ibi_addr;

  always #2.5 clk = ~clk;

  assign sda_i = tgt_sda & ~sda_oe;
  always_comb for (int i = 0; i < NT; i++) tbl_flat[7*i +: 7] = ta[i];

  i3c_req_handler #(.NUM_TGT(NT), .OD_HALF(40), .CLK_PS(5000), .SYNC_STG(2)) i_i3c_req_handler (
    .clk(clk), .rst(rst), .sda_i(sda_i), .addr_tbl(tbl_flat), .addr_vld(va),
    .ibi_en(ibi_en), .hj_en(hj_en), .handoff_rel(handoff_rel),
    .scl_o(scl_o), .sda_oe(sda_oe), .busy(busy), .ibi_ack(ibi_ack),
    .ibi_addr(ibi_addr), .daa_start(daa_start), .hj_nack(hj_nack),
    .ibi_nack(ibi_nack), .unk_req(unk_req)
  );

  int n_chk = 0, n_bad = 0;
  int m_n = -1, m_f = -1;
  int m_kind = 0;          // 0 interrupt, 1 hot-join, 2 unknown
  logic m_ack = 1'b0;
  logic [6:0] m_addr = '0;
  logic h1 = 1'b1, h2 = 1'b1;
  logic [7:0] cur_hdr = 8'hFF;
  logic armed = 1'b0;
  int cyc = 0;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  // reference verdict from the requirements
  task automatic judge(input logic [7:0] h);
    logic known;
    known = 1'b0;
    for (int i = 0; i < NT; i++) if (va[i] && ta[i] == h[7:1]) known = 1'b1;
    m_addr = h[7:1];
    if (h[7:1] == 7'h02) begin m_kind = 1; m_ack = hj_en; end
    else if (known)      begin m_kind = 0; m_ack = h[0] & ibi_en; end
    else                 begin m_kind = 2; m_ack = 1'b0; end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_n = -1; m_f = -1; h1 = 1'b1; h2 = 1'b1;
    end else begin
      if (m_f >= 0) begin
        m_f++;
        if (m_f == HH) m_f = -1;
      end else if (m_n < 0) begin
        if (h2 == 1'b0) begin m_n = 0; judge(cur_hdr); end
      end else if (m_ack && m_n >= 19*HH && handoff_rel) begin
        m_n = -1; m_f = 0;
      end else begin
        m_n++;
        if (!m_ack && m_n == 22*HH) m_n = -1;
      end
      h2 = h1; h1 = sda_i;
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      logic e_scl, e_oe, e_busy, pl;
      e_busy = (m_n >= 0) || (m_f >= 0);
      e_scl = 1'b1; e_oe = 1'b0; pl = 1'b0;
      if (m_n >= 0) begin
        if (m_n < HH)            e_scl = 1'b1;
        else if (m_n < 19*HH)    e_scl = (((m_n - HH) / HH) % 2) == 1;
        else if (m_ack)          e_scl = 1'b0;
        else                     e_scl = (m_n >= 20*HH);
        if (m_n >= 17*HH && m_n < 19*HH) e_oe = m_ack;
        if (m_n >= 19*HH && m_n < 21*HH) e_oe = !m_ack;
        pl = (m_n == 19*HH);
      end
      chk("R1 busy", busy, e_busy);
      chk((m_n >= 19*HH && m_ack) ? "R11 scl hold" : "R2 scl", scl_o, e_scl);
      chk((m_n >= 19*HH) ? "R10 sda_oe stop" : "R9 sda_oe ack", sda_oe, e_oe);
      chk("R6 ibi_ack", ibi_ack, pl && m_ack && m_kind == 0);
      chk("R4 daa_start", daa_start, pl && m_ack && m_kind == 1);
      chk("R5 hj_nack", hj_nack, pl && !m_ack && m_kind == 1);
      chk("R7 ibi_nack", ibi_nack, pl && !m_ack && m_kind == 0);
      chk("R8 unk_req", unk_req, pl && !m_ack && m_kind == 2);
      if (pl && m_ack && m_kind == 0) begin
        n_chk++;
        if (ibi_addr !== m_addr) begin
          n_bad++;
          $display("FAIL R3/R6 ibi_addr: actual %h expected %h", ibi_addr, m_addr);
        end
      end
    end
  end

  task automatic request(input logic [7:0] h, input int hold_cycles);
    cur_hdr = h;
    @(negedge clk); tgt_sda = 1'b0;
    for (int b = 7; b >= 0; b--) begin
      wait (scl_o == 1'b1); wait (scl_o == 1'b0);
      @(negedge clk); tgt_sda = h[b];
    end
    wait (scl_o == 1'b1); wait (scl_o == 1'b0);
    @(negedge clk); tgt_sda = 1'b1;
    while (!((m_n < 0 && m_f < 0) || (m_ack && m_n > 19*HH))) @(negedge clk);
    if (m_n >= 0) begin
      repeat (hold_cycles) @(negedge clk);
      handoff_rel = 1'b1; @(negedge clk); handoff_rel = 1'b0;
    end
    while (m_n >= 0 || m_f >= 0) @(negedge clk);
  endtask

  initial begin
    ta[0] = 7'h31; ta[1] = 7'h45; ta[2] = 7'h12; ta[3] = 7'h7A;
    va = 4'b1011;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 scl_o", scl_o, 1'b1);
    chk("R12 sda_oe", sda_oe, 1'b0);
    chk("R12 busy", busy, 1'b0);
    chk("R12 pulses", ibi_ack | daa_start | hj_nack | ibi_nack | unk_req, 1'b0);
    rst = 1'b0; armed = 1'b1;
    repeat (300) @(negedge clk);                 // R1 idle with SDA high
    request({7'h31, 1'b1}, 40);                  // R6 accepted interrupt
    request({7'h45, 1'b0}, 0);                   // R7 write direction
    ibi_en = 1'b0;
    request({7'h7A, 1'b1}, 0);                   // R7 interrupts disabled
    ibi_en = 1'b1;
    request({7'h02, 1'b0}, 25);                  // R4 hot-join accepted
    request({7'h02, 1'b1}, 3);                   // R4 either direction bit
    hj_en = 1'b0;
    request({7'h02, 1'b0}, 0);                   // R5 hot-join rejected
    hj_en = 1'b1;
    request({7'h12, 1'b1}, 0);                   // R8 invalid entry
    request({7'h55, 1'b1}, 0);                   // R8 unknown address
    request({7'h7A, 1'b1}, 10);                  // R6 last table entry
    request({7'h31, 1'b1}, 1);                   // R11 quick release
    repeat (200) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule